// File: doc/BRIEF.md
# Serial Result Output Shifter

This block is the slave side of a three-wire read port for a converter. A conversion core hands it a 12-bit result in straight natural binary together with a valid strobe. The block keeps the most recent result and sends it out as a 16-bit frame on a serial data pin, one bit per serial clock, with the clock supplied by an external master. The frame is four zero bits followed by the result, most significant bit first. Between frames the data pin floats, shown here as an enable output that a pad cell turns into high impedance.

The serial clock and the start-of-conversion strobe are asynchronous pins. Both are synchronised into the fast system clock, and their edges are detected there, so no flop is clocked by the serial clock. Because of this the block follows the pins a fixed few system cycles late. Each serial clock phase must last at least two system clock periods.

A falling edge on the conversion strobe puts the frame logic back into its idle state, but only when the serial clock is low at that moment. This gives every conversion cycle a known starting point. A read that is still running across such an edge is cut short.

Top module: `srs_shifter`

## Requirements
- R1: A frame is 16 bits, sent in this order: frame positions 0 to 3 are zero, and frame position k (k from 4 to 15) carries result bit 15-k, so the result goes out MSB first.
- R2: While idle, the data enable is low. The first serial clock rising edge raises the enable and drives frame position 0.
- R3: Each serial clock falling edge inside a frame moves the data output on to the next frame position.
- R4: After the 16th falling edge, result bit 0 stays on the data output with the enable high for one system clock. The enable then goes low.
- R5: A rising edge that arrives after a complete frame starts the frame again from position 0. From then on the enable stays high, also after later frames finish and while the clock is stopped, until the next resynchronisation.
- R6: A conversion-strobe falling edge while the serial clock is low clears the bit position and the shifter and drops the enable. The next rising edge starts a frame at position 0.
- R7: A conversion-strobe falling edge while the serial clock is high is ignored. The read goes on with the enable and the data unchanged.
- R8: The result register loads on the valid strobe. A frame carries the value held at its first rising edge. A valid strobe during a read does not change that read.
- R9: The serial clock may pause low for any length of time inside a frame. The enable and the data output hold until the next edge, so a frame can be read in pieces.
- R10: After reset the enable is low and the data output is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_in | input | 1 | Serial clock from the external master (asynchronous) |
| convst_in | input | 1 | Start-of-conversion strobe (asynchronous) |
| res_data | input | RES_W | Conversion result, straight binary |
| res_valid | input | 1 | One-cycle strobe: res_data holds a finished result |
| sdata_out | output | 1 | Serial data value |
| sdata_en | output | 1 | Data output enable; low means high impedance |

## Verification
On every cycle the assertions check the following. The enable rises only after a detected serial clock rise. Every shift moves the next frame bit onto the pin. Every frame load puts four zeros above the latched result. A qualified strobe edge always returns the logic to idle. The hold-then-release at the end of a frame and the sticky enable after an overrun are checked on every cycle as well. Only the bench scenarios can show the full bit order for many result values. The same holds for reading in separate pieces, the strobe being ignored while the clock is high, and a mid-read result update leaving the frame in progress untouched.

// File: rtl/srs_pkg.sv
package srs_pkg;
   // Synchronised copy of an asynchronous pin plus its one-cycle-older value.
   typedef struct packed {
      logic level;
      logic prev;
   } srs_lvl_t;
endpackage

// File: rtl/srs_sync.sv
module srs_sync #(
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             async_i,
   output srs_pkg::srs_lvl_t sig_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("srs_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], async_i};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign sig_o.level = chain_q[STAGES-1];
   assign sig_o.prev  = prev_q;
endmodule

// File: rtl/srs_frame_ctl.sv
module srs_frame_ctl #(
   parameter int FRAME_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  srs_pkg::srs_lvl_t sc,
   input  srs_pkg::srs_lvl_t cv,
   output logic              load_o,
   output logic              shift_o,
   output logic              clr_o,
   output logic              oe_o
);
   localparam int CNT_W = $clog2(FRAME_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

   logic s_rise, s_fall, resync, adv;
   logic [CNT_W-1:0] cnt_q;
   logic oe_q, done_q, rerun_q, rel_q, armed_q;

   assign s_rise  = sc.level & ~sc.prev;
   assign s_fall  = ~sc.level & sc.prev;
   assign resync  = cv.prev & ~cv.level & ~sc.level;
   assign load_o  = s_rise & armed_q & ~resync;
   assign adv     = s_fall & oe_q & ~armed_q & ~resync;
   assign shift_o = adv & (cnt_q != LAST);
   assign clr_o   = resync;
   assign oe_o    = oe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         oe_q    <= 1'b0;
         done_q  <= 1'b0;
         rerun_q <= 1'b0;
         rel_q   <= 1'b0;
         armed_q <= 1'b1;
      end else if (resync) begin
         cnt_q   <= '0;
         oe_q    <= 1'b0;
         done_q  <= 1'b0;
         rerun_q <= 1'b0;
         rel_q   <= 1'b0;
         armed_q <= 1'b1;
      end else begin
         if (rel_q) begin
            rel_q <= 1'b0;
            cnt_q <= '0;
            oe_q  <= rerun_q;
         end
         if (load_o) begin
            armed_q <= 1'b0;
            oe_q    <= 1'b1;
            if (done_q) rerun_q <= 1'b1;
         end
         if (adv) begin
            if (cnt_q == LAST) begin
               rel_q   <= 1'b1;
               done_q  <= 1'b1;
               armed_q <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   // R2: the enable only ever rises after a detected serial clock rise
   assert_en_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oe_q) |-> $past(s_rise));

   // R6: a qualified strobe edge leaves the logic idle
   assert_resync_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      resync |=> (!oe_q && armed_q && cnt_q == '0));

   // R4: the last bit is held one cycle, then the output floats
   assert_hold_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && cnt_q == LAST && !rerun_q) |=> (oe_q ##1 !oe_q));

   // R5: once restarted, the output stays driven until a resync
   assert_sticky_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rerun_q && !resync) |=> oe_q);
endmodule

// File: rtl/srs_shifter.sv
module srs_shifter #(
   parameter int RES_W       = 12,
   parameter int FRAME_W     = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sclk_in,
   input  logic             convst_in,
   input  logic [RES_W-1:0] res_data,
   input  logic             res_valid,
   output logic             sdata_out,
   output logic             sdata_en
);
   localparam int LEAD = FRAME_W - RES_W;

   generate
      if (LEAD < 1) begin : g_bad_frame
         $error("srs_shifter: FRAME_W must exceed RES_W");
      end
   endgenerate

   srs_pkg::srs_lvl_t sc_sig, cv_sig;
   logic load, shift, clr;
   logic [RES_W-1:0]   res_q;
   logic [FRAME_W-1:0] shreg_q;

   srs_sync #(.STAGES(SYNC_STAGES)) i_sync_sclk (
      .clk(clk), .rst_n(rst_n), .async_i(sclk_in), .sig_o(sc_sig));

   srs_sync #(.STAGES(SYNC_STAGES)) i_sync_conv (
      .clk(clk), .rst_n(rst_n), .async_i(convst_in), .sig_o(cv_sig));

   srs_frame_ctl #(.FRAME_W(FRAME_W)) i_ctl (
      .clk(clk), .rst_n(rst_n), .sc(sc_sig), .cv(cv_sig),
      .load_o(load), .shift_o(shift), .clr_o(clr), .oe_o(sdata_en));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         res_q <= '0;
      else if (res_valid) res_q <= res_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      shreg_q <= '0;
      else if (clr)    shreg_q <= '0;
      else if (load)   shreg_q <= {{LEAD{1'b0}}, res_q};
      else if (shift)  shreg_q <= {shreg_q[FRAME_W-2:0], 1'b0};
   end

   assign sdata_out = shreg_q[FRAME_W-1];

   // R3: each shift brings the next frame bit onto the pin
   assert_shift_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
      shift |=> (sdata_out == $past(shreg_q[FRAME_W-2])));

   // R1: a freshly loaded frame starts with the zero lead bits
   assert_lead_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (shreg_q[FRAME_W-1 -: LEAD] == '0));

   // R8: the frame snapshot equals the latched result
   assert_snapshot_R8: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (shreg_q[RES_W-1:0] == $past(res_q)));
endmodule

// File: tb/test_srs_shifter.sv
module test_srs_shifter;
   localparam int RES_W = 12;
   localparam int FRAME_W = 16;
   localparam int LEAD = FRAME_W - RES_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk_in = 1'b0;
   logic convst_in = 1'b1;
   logic [RES_W-1:0] res_data = '0;
   logic res_valid = 1'b0;
   logic sdata_out, sdata_en;

   int total = 0;
   int bad = 0;
   int cyc = 0;

   always #10 clk = ~clk;

   srs_shifter #(.RES_W(RES_W), .FRAME_W(FRAME_W), .SYNC_STAGES(2)) i_srs_shifter (
      .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .convst_in(convst_in),
      .res_data(res_data), .res_valid(res_valid),
      .sdata_out(sdata_out), .sdata_en(sdata_en));

   always @(posedge clk) cyc <= cyc + 1;

   initial begin
      wait (cyc >= 200000);
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=%0d expected<200000 cycles", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string tag, input int act, input int exp);
      total = total + 1;
      if (act != exp) begin
         bad = bad + 1;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int ebit(input int v, input int k);
      if (k < LEAD) return 0;
      return (v >> (FRAME_W - 1 - k)) & 1;
   endfunction

   task automatic sc_hi();
      sclk_in = 1'b1;
      tick(4);
   endtask

   task automatic sc_lo();
      sclk_in = 1'b0;
      tick(4);
   endtask

   task automatic load_res(input int v);
      res_data  = RES_W'(v);
      res_valid = 1'b1;
      tick(1);
      res_valid = 1'b0;
      tick(1);
   endtask

   task automatic cv_pulse();
      convst_in = 1'b1;
      tick(4);
      convst_in = 1'b0;
      tick(4);
   endtask

   // rise, check, fall for positions from..to (to at most 14)
   task automatic read_bits(input int v, input int from, input int to);
      for (int k = from; k <= to; k++) begin
         sc_hi();
         check($sformatf("R1/R3 bit %0d of 0x%03h", k, v), sdata_out, ebit(v, k));
         check($sformatf("R2 enable at bit %0d", k), sdata_en, 1);
         sc_lo();
      end
   endtask

   // last position: rise, check, fall, then hold and release timing
   task automatic end_frame(input int v, input int stay);
      sc_hi();
      check($sformatf("R1 bit 15 of 0x%03h", v), sdata_out, ebit(v, 15));
      sclk_in = 1'b0;
      tick(3);
      check("R4 hold enable", sdata_en, 1);
      check("R4 hold last bit", sdata_out, v & 1);
      tick(1);
      check(stay ? "R5 enable stays" : "R4 released", sdata_en, stay);
      tick(2);
   endtask

   initial begin
      tick(5);
      rst_n = 1'b1;
      tick(4);
      check("R10 enable after reset", sdata_en, 0);
      check("R10 data after reset", sdata_out, 0);

      // sweep: one-hot values and patterns
      for (int i = 0; i < 16; i++) begin
         int v;
         case (i)
            12: v = 12'h000;
            13: v = 12'hFFF;
            14: v = 12'hA5A;
            15: v = 12'h5A5;
            default: v = 1 << i;
         endcase
         load_res(v);
         cv_pulse();
         check("R2 idle before frame", sdata_en, 0);
         read_bits(v, 0, 14);
         end_frame(v, 0);
      end

      // R9: read in two pieces with a long low pause
      load_res(12'h9C3);
      cv_pulse();
      read_bits(12'h9C3, 0, 7);
      tick(40);
      check("R9 enable during pause", sdata_en, 1);
      check("R9 data during pause", sdata_out, ebit(12'h9C3, 8));
      read_bits(12'h9C3, 8, 14);
      end_frame(12'h9C3, 0);

      // R8: new result mid-read does not disturb the frame
      load_res(12'h3E1);
      cv_pulse();
      read_bits(12'h3E1, 0, 5);
      load_res(12'h7B4);
      read_bits(12'h3E1, 6, 14);
      end_frame(12'h3E1, 0);
      cv_pulse();
      read_bits(12'h7B4, 0, 14);   // R8 next frame shows new value
      end_frame(12'h7B4, 0);

      // R5: extra clocks restart the frame and keep the pin driven
      load_res(12'h2D6);
      read_bits(12'h2D6, 0, 14);
      end_frame(12'h2D6, 1);
      tick(20);
      check("R5 enable while clock stopped", sdata_en, 1);
      read_bits(12'h2D6, 0, 14);
      end_frame(12'h2D6, 1);
      cv_pulse();
      check("R6 enable after resync", sdata_en, 0);

      // R6: resync in the middle of a read
      load_res(12'h6A9);
      cv_pulse();
      read_bits(12'h6A9, 0, 5);
      cv_pulse();
      check("R6 enable after mid-read resync", sdata_en, 0);
      check("R6 data cleared", sdata_out, 0);
      read_bits(12'h6A9, 0, 14);
      end_frame(12'h6A9, 0);

      // R7: strobe edge with the serial clock high is ignored
      load_res(12'h1C7);
      cv_pulse();
      read_bits(12'h1C7, 0, 4);
      sc_hi();
      check("R7 bit 5 before strobe", sdata_out, ebit(12'h1C7, 5));
      convst_in = 1'b1;
      tick(4);
      convst_in = 1'b0;
      tick(4);
      check("R7 enable kept", sdata_en, 1);
      check("R7 data kept", sdata_out, ebit(12'h1C7, 5));
      sc_lo();
      read_bits(12'h1C7, 6, 14);
      end_frame(12'h1C7, 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule